// File: doc/BRIEF.md
# Post-Processing Engine Control and Interrupt Register

This block is a single memory-mapped control and status word for a picture post-processing engine that runs beside a video decoder. Software writes the word to launch one standalone job, to choose whether the engine runs in lockstep with the decoder or on a separate picture, and to mask the engine's interrupt. Hardware updates the same word to report that a job has finished and that a bus error occurred.

The engine sees a one-cycle launch pulse and returns a one-cycle completion pulse and a one-cycle bus-error pulse. The block drives a single interrupt line. That line combines this engine's pending flag, gated by the mask bit, with the decoder's own interrupt flag.

The register port is plain. A write strobe with a data word updates the writable fields at the clock edge. The read data always shows the current register contents combinationally, so there is no read strobe and no back-pressure. All control and status pins are level or single-cycle pulse signals with no handshake.

Top module: `ppc_ctrl_reg`

## Requirements
- R1: After reset every bit of the read word is 0, the launch pulse is low, and the interrupt output follows only the decoder flag.
- R2: A write with bit 0 set while bit 0 reads 0 makes bit 0 read 1 and raises the launch output for exactly one cycle, both visible in the cycle after the write edge.
- R3: A completion pulse while bit 0 reads 1 clears bit 0 at the next edge. A completion pulse while bit 0 reads 0 changes nothing.
- R4: A write with bit 0 set while bit 0 already reads 1 produces no launch pulse and leaves the word unchanged apart from the other writable fields.
- R5: Bit 1 (lockstep mode) and bit 4 (interrupt mask) take the written value on every write and hold it otherwise.
- R6: Bit 8 (pending flag) is set by an accepted completion or by a bus-error pulse. Otherwise a write loads it with the written value. A hardware set wins over a software clear in the same cycle.
- R7: The interrupt output equals the decoder flag OR (bit 8 AND NOT bit 4), combinationally.
- R8: With bit 1 reading 0, bit 12 (ready) clears when a launch is accepted and sets on an accepted completion. With bit 1 reading 1, bit 12 keeps its value.
- R9: Bit 16 (bus error) is set by a bus-error pulse and cleared by a write with bit 16 at 0. Writing 1 never sets it, and a pulse wins over a clearing write in the same cycle.
- R10: All bits other than 0, 1, 4, 8, 12 and 16 read as 0 whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DW | Register write data |
| rd_data | output | DW | Current register contents |
| start_o | output | 1 | One-cycle job launch pulse to the engine |
| done_i | input | 1 | One-cycle job completion pulse from the engine |
| bus_err_i | input | 1 | One-cycle bus error pulse from the engine |
| dec_irq_i | input | 1 | Decoder interrupt flag |
| irq_o | output | 1 | Combined interrupt line |

## Verification
The bench builds the block with its default parameters: a 32-bit word and the field positions listed above. These let a write of all ones show that the unused bits stay at zero. The defaults also reach the corner cases that need two events in one cycle: a clearing write against a bus-error pulse, and a second launch written while a job is still running. Lockstep mode is switched on between two jobs, so the ready flag can be seen held across a launch and a completion and then released again.

// File: rtl/ppc_pkg.sv
package ppc_pkg;

  // Decoded register fields, one flop each
  typedef struct packed {
    logic en;
    logic pipe;
    logic dis;
    logic iset;
    logic rdy;
    logic be;
  } ppc_state_t;

  localparam int unsigned PPC_CFG_BITS = 2;

endpackage

// File: rtl/ppc_job_ctl.sv
module ppc_job_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic go_req,
  input  logic done_i,
  input  logic pipe_mode,
  output logic busy,
  output logic start_o,
  output logic ready,
  output logic job_end
);

  logic launch;

  assign launch  = go_req & ~busy;
  assign job_end = done_i & busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      start_o <= 1'b0;
      ready   <= 1'b0;
    end else begin
      start_o <= launch;
      if (launch)       busy <= 1'b1;
      else if (job_end) busy <= 1'b0;
      if (!pipe_mode) begin
        if (launch)       ready <= 1'b0;
        else if (job_end) ready <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ppc_cfg_reg.sv
module ppc_cfg_reg #(
  parameter int unsigned NB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [NB-1:0] wr_bits,
  output logic [NB-1:0] q
);

  for (genvar i = 0; i < NB; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)     q[i] <= 1'b0;
      else if (wr_en) q[i] <= wr_bits[i];
    end
  end

endmodule

// File: rtl/ppc_flag_ctl.sv
module ppc_flag_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_iset,
  input  logic wr_be,
  input  logic job_end,
  input  logic bus_err_i,
  output logic iset,
  output logic be
);

  logic hw_evt;
  assign hw_evt = job_end | bus_err_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iset <= 1'b0;
      be   <= 1'b0;
    end else begin
      if (hw_evt)     iset <= 1'b1;
      else if (wr_en) iset <= wr_iset;
      if (bus_err_i)            be <= 1'b1;
      else if (wr_en && !wr_be) be <= 1'b0;
    end
  end

endmodule

// File: rtl/ppc_rd_map.sv
module ppc_rd_map
  import ppc_pkg::*;
#(
  parameter int unsigned DW       = 32,
  parameter int unsigned EN_BIT   = 0,
  parameter int unsigned PIPE_BIT = 1,
  parameter int unsigned DIS_BIT  = 4,
  parameter int unsigned ISET_BIT = 8,
  parameter int unsigned RDY_BIT  = 12,
  parameter int unsigned BE_BIT   = 16
) (
  input  ppc_state_t    st,
  output logic [DW-1:0] rd_data
);

  for (genvar i = 0; i < DW; i++) begin : g_rd
    if (i == EN_BIT)        begin : g_en   assign rd_data[i] = st.en;   end
    else if (i == PIPE_BIT) begin : g_pipe assign rd_data[i] = st.pipe; end
    else if (i == DIS_BIT)  begin : g_dis  assign rd_data[i] = st.dis;  end
    else if (i == ISET_BIT) begin : g_iset assign rd_data[i] = st.iset; end
    else if (i == RDY_BIT)  begin : g_rdy  assign rd_data[i] = st.rdy;  end
    else if (i == BE_BIT)   begin : g_be   assign rd_data[i] = st.be;   end
    else                    begin : g_zero assign rd_data[i] = 1'b0;    end
  end

endmodule

// File: rtl/ppc_ctrl_reg.sv
module ppc_ctrl_reg
  import ppc_pkg::*;
#(
  parameter int unsigned DW       = 32,
  parameter int unsigned EN_BIT   = 0,
  parameter int unsigned PIPE_BIT = 1,
  parameter int unsigned DIS_BIT  = 4,
  parameter int unsigned ISET_BIT = 8,
  parameter int unsigned RDY_BIT  = 12,
  parameter int unsigned BE_BIT   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          start_o,
  input  logic          done_i,
  input  logic          bus_err_i,
  input  logic          dec_irq_i,
  output logic          irq_o
);

  ppc_state_t              st;
  logic [PPC_CFG_BITS-1:0] cfg_q;
  logic                    job_end;

  ppc_job_ctl u_job (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_req    (wr_en & wr_data[EN_BIT]),
    .done_i    (done_i),
    .pipe_mode (st.pipe),
    .busy      (st.en),
    .start_o   (start_o),
    .ready     (st.rdy),
    .job_end   (job_end)
  );

  ppc_cfg_reg #(.NB(PPC_CFG_BITS)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_bits ({wr_data[DIS_BIT], wr_data[PIPE_BIT]}),
    .q       (cfg_q)
  );

  assign st.pipe = cfg_q[0];
  assign st.dis  = cfg_q[1];

  ppc_flag_ctl u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_iset   (wr_data[ISET_BIT]),
    .wr_be     (wr_data[BE_BIT]),
    .job_end   (job_end),
    .bus_err_i (bus_err_i),
    .iset      (st.iset),
    .be        (st.be)
  );

  ppc_rd_map #(
    .DW(DW), .EN_BIT(EN_BIT), .PIPE_BIT(PIPE_BIT), .DIS_BIT(DIS_BIT),
    .ISET_BIT(ISET_BIT), .RDY_BIT(RDY_BIT), .BE_BIT(BE_BIT)
  ) u_map (
    .st      (st),
    .rd_data (rd_data)
  );

  assign irq_o = dec_irq_i | (st.iset & ~st.dis);

endmodule

// File: rtl/ppc_ctrl_reg_chk.sv
module ppc_ctrl_reg_chk #(
  parameter int unsigned DW       = 32,
  parameter int unsigned EN_BIT   = 0,
  parameter int unsigned PIPE_BIT = 1,
  parameter int unsigned DIS_BIT  = 4,
  parameter int unsigned ISET_BIT = 8,
  parameter int unsigned RDY_BIT  = 12,
  parameter int unsigned BE_BIT   = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] rd_data,
  input logic          start_o,
  input logic          done_i,
  input logic          bus_err_i,
  input logic          dec_irq_i,
  input logic          irq_o
);

  localparam logic [DW-1:0] USED_MASK =
    (DW'(1) << EN_BIT) | (DW'(1) << PIPE_BIT) | (DW'(1) << DIS_BIT) |
    (DW'(1) << ISET_BIT) | (DW'(1) << RDY_BIT) | (DW'(1) << BE_BIT);

  // R2
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[EN_BIT] && !rd_data[EN_BIT] |=> start_o && rd_data[EN_BIT]);

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);

  // R3
  finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[EN_BIT] && done_i |=> !rd_data[EN_BIT]);

  // R4
  no_relaunch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[EN_BIT] |=> !start_o);

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && rd_data[EN_BIT]) || bus_err_i |=> rd_data[ISET_BIT]);

  // R7
  dec_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_irq_i |-> irq_o);

  // R7
  mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DIS_BIT] && !dec_irq_i |-> !irq_o);

  // R7
  pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[ISET_BIT] && !rd_data[DIS_BIT] |-> irq_o);

  // R8
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[PIPE_BIT] |=> $stable(rd_data[RDY_BIT]));

  // R9
  be_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err_i |=> rd_data[BE_BIT]);

  // R9
  be_no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_err_i && !rd_data[BE_BIT] |=> !rd_data[BE_BIT]);

  // R10
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~USED_MASK) == '0);

endmodule

bind ppc_ctrl_reg ppc_ctrl_reg_chk #(
  .DW(DW), .EN_BIT(EN_BIT), .PIPE_BIT(PIPE_BIT), .DIS_BIT(DIS_BIT),
  .ISET_BIT(ISET_BIT), .RDY_BIT(RDY_BIT), .BE_BIT(BE_BIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .start_o   (start_o),
  .done_i    (done_i),
  .bus_err_i (bus_err_i),
  .dec_irq_i (dec_irq_i),
  .irq_o     (irq_o)
);

// File: tb/sim_ppc_ctrl_reg.sv
module sim_ppc_ctrl_reg;

  localparam int DW = 32;
  // Field positions as stated in the requirements
  localparam int B_EN = 0, B_PIPE = 1, B_DIS = 4, B_ISET = 8, B_RDY = 12, B_BE = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          start_o;
  logic          done_i = 1'b0;
  logic          bus_err_i = 1'b0;
  logic          dec_irq_i = 1'b0;
  logic          irq_o;

  always #10 clk = ~clk;

  ppc_ctrl_reg u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .start_o(start_o), .done_i(done_i), .bus_err_i(bus_err_i),
    .dec_irq_i(dec_irq_i), .irq_o(irq_o)
  );

  typedef struct {
    logic [DW-1:0] rd;
    logic          irq;
    logic          start;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done_run = 0;

  // Reference state kept from the requirements
  logic m_en = 0, m_pipe = 0, m_dis = 0, m_iset = 0, m_rdy = 0, m_be = 0;

  function automatic logic [DW-1:0] m_word();
    logic [DW-1:0] w = '0;
    w[B_EN] = m_en; w[B_PIPE] = m_pipe; w[B_DIS] = m_dis;
    w[B_ISET] = m_iset; w[B_RDY] = m_rdy; w[B_BE] = m_be;
    return w;
  endfunction

  task automatic step(input logic w, input logic [DW-1:0] d, input logic dn,
                      input logic be, input logic dc, input string tag);
    logic launch, fin, n_en, n_rdy;
    exp_t e;
    @(negedge clk);
    wr_en = w; wr_data = d; done_i = dn; bus_err_i = be; dec_irq_i = dc;
    launch = w && d[B_EN] && !m_en;                 // R2, R4
    fin    = dn && m_en;                            // R3
    n_en   = launch ? 1'b1 : (fin ? 1'b0 : m_en);
    n_rdy  = m_rdy;                                 // R8
    if (!m_pipe) begin
      if (launch)   n_rdy = 1'b0;
      else if (fin) n_rdy = 1'b1;
    end
    if (fin || be) m_iset = 1'b1;                   // R6
    else if (w)    m_iset = d[B_ISET];
    if (be)                m_be = 1'b1;             // R9
    else if (w && !d[B_BE]) m_be = 1'b0;
    if (w) begin m_pipe = d[B_PIPE]; m_dis = d[B_DIS]; end  // R5
    m_en = n_en; m_rdy = n_rdy;
    e.rd = m_word(); e.irq = dc | (m_iset & ~m_dis); e.start = launch;  // R7
    e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk);
  endtask

  // Monitor: compares each expected item after the edge that produces it
  initial begin
    forever begin
      @(posedge clk);
      #5;
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_chk++;
        if (rd_data !== e.rd || irq_o !== e.irq || start_o !== e.start) begin
          n_fail++;
          $display("FAIL %s: rd=%h irq=%b start=%b expected rd=%h irq=%b start=%b",
                   e.tag, rd_data, irq_o, start_o, e.rd, e.irq, e.start);
        end
      end
    end
  end

  localparam logic [DW-1:0] W_EN   = 32'h1;
  localparam logic [DW-1:0] W_PIPE = 32'h2;
  localparam logic [DW-1:0] W_DIS  = 32'h10;
  localparam logic [DW-1:0] W_ISET = 32'h100;
  localparam logic [DW-1:0] W_BE   = 32'h10000;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    step(0, '0, 0, 0, 0, "R1 reset state");
    step(0, '0, 0, 0, 1, "R1 decoder flag after reset");
    step(1, W_EN, 0, 0, 0, "R2 launch accepted");
    step(0, '0, 0, 0, 0, "R2 launch pulse ends");
    step(1, W_EN, 0, 0, 0, "R4 relaunch while busy ignored");
    step(0, '0, 1, 0, 0, "R3 completion clears enable, R8 ready set, R6 flag set");
    step(0, '0, 1, 0, 0, "R3 completion while idle ignored");
    step(1, '0, 0, 0, 0, "R6 software clears flag");
    step(1, W_ISET, 0, 0, 0, "R6 software sets flag, R7 irq");
    step(1, W_DIS | W_ISET, 0, 0, 0, "R7 mask hides flag, R5 mask written");
    step(0, '0, 0, 0, 1, "R7 decoder flag passes mask");
    step(1, W_DIS, 1, 0, 0, "R3 idle completion keeps flag clear");
    step(0, '0, 0, 1, 0, "R9 bus error sets bit, R6 sets flag");
    step(1, W_DIS | W_BE, 0, 0, 0, "R9 writing one keeps bit");
    step(1, W_DIS, 0, 0, 0, "R9 writing zero clears bit");
    step(1, W_DIS, 0, 1, 0, "R9 pulse wins over clearing write");
    step(1, '0, 0, 0, 0, "R9 clear, R6 clear, R5 mask off");
    step(1, W_PIPE, 0, 0, 0, "R5 lockstep mode written");
    step(1, W_PIPE | W_EN, 0, 0, 0, "R8 launch in lockstep keeps ready");
    step(0, '0, 1, 0, 0, "R8 completion in lockstep keeps ready");
    step(1, W_EN, 0, 0, 0, "R8 launch with mode off, ready held for old mode");
    step(0, '0, 1, 0, 0, "R8 completion restores ready");
    step(1, '0, 0, 0, 0, "R6 clear after lockstep");
    step(1, W_EN, 0, 0, 0, "R8 launch clears ready");
    step(0, '0, 1, 1, 0, "R6 completion and bus error together");
    step(1, '1, 0, 0, 0, "R10 unused bits read zero");
    step(0, '0, 0, 0, 0, "R10 idle after all ones");
    repeat (3) @(posedge clk);
    done_run = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done_run && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done_run) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule